// File: doc/BRIEF.md
# Integer Execution Unit with Status Flags and Range Trap

This unit executes one of three 32-bit integer operations per request: addition, signed division and unsigned division. Along with the result it produces an updated copy of the four-bit status word it was handed: carry, overflow, the compare flag and the overflow-trap enable. When an operation goes out of range it raises a range-exception strobe, so the pipeline can redirect to its handler.

Addition completes one cycle after the request is accepted. A division by a non-zero divisor runs on a serial shift-subtract engine and completes about thirty-four cycles after acceptance. A division by zero never starts the engine: it completes in one cycle with carry set, the strobe raised and no register write.

Requests use a valid/ready handshake. `in_ready` falls while a division is in flight, and a request presented then is held off until the engine is free. The completion side has no back-pressure. `out_valid` is a one-cycle pulse that the consumer must take in the cycle it appears. `result`, `wr_en`, `status_out` and `range_exc` belong to that pulse.

Top module: `int_exec_unit`

## Requirements
- R1: An accepted add (op code 0) produces out_valid and wr_en on the next cycle, with result equal to opa plus opb modulo 2^32.
- R2: On add, the overflow bit (status bit 1) is set when both operands have the same sign and the sum's sign differs from it, and is cleared otherwise.
- R3: On add, the carry bit (status bit 0) is set exactly when the unsigned sum is less than opa.
- R4: On add with set_flag_en high, the compare flag (status bit 2) is set when the sum is zero and cleared when it is not; with set_flag_en low it keeps the value from status_in.
- R5: On add, range_exc pulses together with out_valid exactly when the trap enable (status bit 3) and the new overflow bit are both set.
- R6: A signed (op code 1) or unsigned (op code 2) divide with a zero divisor completes on the next cycle with wr_en low, carry set, range_exc high and the other status bits taken from status_in.
- R7: A signed divide with a non-zero divisor writes the quotient truncated toward zero; the most negative value divided by minus one yields 0x80000000; the status word equals status_in and range_exc stays low.
- R8: An unsigned divide with a non-zero divisor writes the unsigned quotient; the status word equals status_in and range_exc stays low.
- R9: While a non-zero divide is in flight, in_ready is low, and in_valid has no effect: no extra completion appears and the divide result is undisturbed.
- R10: Op code 3 completes on the next cycle with wr_en low, range_exc low and status_out equal to status_in.
- R11: During and right after reset, out_valid, wr_en and range_exc are low and in_ready is high.
- R12: Each accepted request yields exactly one single-cycle out_valid pulse, and wr_en and range_exc are only high together with out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| op | input | 2 | 0 add, 1 signed divide, 2 unsigned divide, 3 no-op |
| opa | input | 32 | First operand / dividend |
| opb | input | 32 | Second operand / divisor |
| set_flag_en | input | 1 | Let an add update the compare flag |
| status_in | input | 4 | Current status: bit0 carry, bit1 overflow, bit2 compare flag, bit3 trap enable |
| out_valid | output | 1 | Completion pulse |
| result | output | 32 | Result value |
| wr_en | output | 1 | Destination write enable |
| status_out | output | 4 | Updated status, same bit layout as status_in |
| range_exc | output | 1 | Range-exception strobe |

## Verification
The checker watches single-cycle relations on every cycle: the add latency and sum, the trap strobe agreeing with the reported overflow and enable bits, the zero-divisor completion shape, no-op passthrough, and the fall of in_ready after a divide starts. Whether the carry and overflow rules are right across sign patterns, whether quotients are right (including truncation toward zero and the most negative value over minus one), and whether requests held off during a divide are really dropped are shown only by the bench's directed scenarios, which compare against a reference model.

// File: rtl/ieu_pkg.sv
package ieu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_DIVS = 2'd1,
    OP_DIVU = 2'd2,
    OP_NOP  = 2'd3
  } ieu_op_e;

  // Status word layout; the pipeline decodes these positions.
  typedef struct packed {
    logic ove;  // bit 3: overflow trap enable
    logic f;    // bit 2: compare flag
    logic ov;   // bit 1: signed overflow
    logic cy;   // bit 0: carry / divide-by-zero marker
  } ieu_sr_t;

endpackage

// File: rtl/ieu_add_flags.sv
module ieu_add_flags #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf,
  output logic         zero
);
  localparam int MSB = W - 1;

  logic [W:0] wide;

  always_comb begin
    wide  = {1'b0, a} + {1'b0, b};
    sum   = wide[W-1:0];
    // Carry-out is the same event as "unsigned sum below first operand".
    carry = wide[W];
    // Like-signed inputs whose sum flips sign.
    ovf   = (a[MSB] ~^ b[MSB]) & (wide[MSB] ^ a[MSB]);
    zero  = (wide[W-1:0] == '0);
  end
endmodule

// File: rtl/ieu_serial_div.sv
module ieu_serial_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  den_q;
  logic          neg_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          fin_q;

  logic [W:0]    rem_sh;
  logic [W:0]    trial;
  logic [W-1:0]  mag_a;
  logic [W-1:0]  mag_b;

  always_comb begin
    mag_a  = (is_signed && dividend[W-1]) ? (~dividend + 1'b1) : dividend;
    mag_b  = (is_signed && divisor[W-1])  ? (~divisor  + 1'b1) : divisor;
    rem_sh = {rem_q[W-1:0], quo_q[W-1]};
    trial  = rem_sh - {1'b0, den_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      neg_q <= 1'b0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start && !run_q && !fin_q) begin
        rem_q <= '0;
        quo_q <= mag_a;
        den_q <= mag_b;
        neg_q <= is_signed & (dividend[W-1] ^ divisor[W-1]);
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (!trial[W]) begin
          rem_q <= trial;
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= rem_sh;
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = run_q | fin_q;
  assign done     = fin_q;
  assign quotient = neg_q ? (~quo_q + 1'b1) : quo_q;
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import ieu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         set_flag_en,
  input  logic [3:0]   status_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic [3:0]   status_out,
  output logic         range_exc
);
  ieu_op_e  op_e;
  ieu_sr_t  sr_in;
  ieu_sr_t  sr_add;
  ieu_sr_t  sr_hold;
  logic     accept;
  logic     is_div;
  logic     div_zero;
  logic     div_start;
  logic     div_busy;
  logic     div_done;
  logic [W-1:0] div_quot;
  logic [W-1:0] add_sum;
  logic     add_cy;
  logic     add_ov;
  logic     add_zero;

  assign op_e      = ieu_op_e'(op);
  assign sr_in     = ieu_sr_t'(status_in);
  assign in_ready  = ~div_busy;
  assign accept    = in_valid & in_ready;
  assign is_div    = (op_e == OP_DIVS) || (op_e == OP_DIVU);
  assign div_zero  = (opb == '0);
  assign div_start = accept & is_div & ~div_zero;

  ieu_add_flags #(.W(W)) u_add (
    .a     (opa),
    .b     (opb),
    .sum   (add_sum),
    .carry (add_cy),
    .ovf   (add_ov),
    .zero  (add_zero)
  );

  ieu_serial_div #(.W(W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (div_start),
    .is_signed (op_e == OP_DIVS),
    .dividend  (opa),
    .divisor   (opb),
    .busy      (div_busy),
    .done      (div_done),
    .quotient  (div_quot)
  );

  always_comb begin
    sr_add    = sr_in;
    sr_add.cy = add_cy;
    sr_add.ov = add_ov;
    if (set_flag_en) sr_add.f = add_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_hold <= '0;
    end else if (div_start) begin
      sr_hold <= sr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      wr_en      <= 1'b0;
      status_out <= '0;
      range_exc  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      range_exc <= 1'b0;
      if (accept) begin
        unique case (op_e)
          OP_ADD: begin
            out_valid  <= 1'b1;
            result     <= add_sum;
            wr_en      <= 1'b1;
            status_out <= sr_add;
            range_exc  <= sr_in.ove & add_ov;
          end
          OP_DIVS, OP_DIVU: begin
            if (div_zero) begin
              out_valid  <= 1'b1;
              status_out <= status_in | 4'b0001;
              range_exc  <= 1'b1;
            end
          end
          default: begin
            out_valid  <= 1'b1;
            status_out <= status_in;
          end
        endcase
      end else if (div_done) begin
        out_valid  <= 1'b1;
        result     <= div_quot;
        wr_en      <= 1'b1;
        status_out <= sr_hold;
      end
    end
  end
endmodule

// File: rtl/ieu_checker.sv
module ieu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [1:0]   op,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [3:0]   status_in,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic [3:0]   status_out,
  input logic         range_exc
);
  logic         acc;
  logic [W-1:0] ref_sum;
  assign acc     = in_valid & in_ready;
  assign ref_sum = opa + opb;

  p_add_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 2'd0) |=> (out_valid && wr_en && result == $past(ref_sum)));

  p_trap_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 2'd0) |=> (range_exc == (status_out[3] && status_out[1])));

  p_div_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == 2'd1 || op == 2'd2) && opb == '0)
      |=> (out_valid && !wr_en && range_exc && status_out == ($past(status_in) | 4'b0001)));

  p_div_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (op == 2'd1 || op == 2'd2) && opb != '0) |=> !in_ready);

  p_nop_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 2'd3) |=> (out_valid && !wr_en && !range_exc && status_out == $past(status_in)));

  p_wr_in_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid);

  p_exc_in_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    range_exc |-> out_valid);
endmodule

bind int_exec_unit ieu_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .op         (op),
  .opa        (opa),
  .opb        (opb),
  .status_in  (status_in),
  .out_valid  (out_valid),
  .result     (result),
  .wr_en      (wr_en),
  .status_out (status_out),
  .range_exc  (range_exc)
);

// File: tb/int_exec_unit_bench.sv
`timescale 1ns/1ps
module int_exec_unit_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   op = 2'd0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         set_flag_en = 1'b0;
  logic [3:0]   status_in = 4'h0;
  logic         out_valid;
  logic [W-1:0] result;
  logic         wr_en;
  logic [3:0]   status_out;
  logic         range_exc;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  int_exec_unit #(.W(W)) u_int_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .opa(opa), .opb(opb), .set_flag_en(set_flag_en),
    .status_in(status_in), .out_valid(out_valid), .result(result),
    .wr_en(wr_en), .status_out(status_out), .range_exc(range_exc)
  );

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Issue one request and wait for its completion pulse.
  task automatic run_op(input logic [1:0] o, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic sf, input logic [3:0] st,
                        output logic [W-1:0] r, output logic w,
                        output logic [3:0] s, output logic x);
    int guard;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    op = o; opa = a; opb = b; set_flag_en = sf; status_in = st; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    guard = 0;
    while (!out_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    chk("R12", "completion seen", {31'd0, out_valid}, 1);
    r = result; w = wr_en; s = status_out; x = range_exc;
    @(negedge clk);
    chk("R12", "pulse ends", {29'd0, out_valid, wr_en, range_exc}, 0);
  endtask

  task automatic t_add(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic sf, input logic [3:0] st);
    logic [W-1:0] r, sum; logic w, x, ov, cy, f; logic [3:0] s;
    sum = a + b;
    ov  = ($signed(a) < 0 && $signed(b) < 0 && $signed(sum) >= 0) ||
          ($signed(a) >= 0 && $signed(b) >= 0 && $signed(sum) < 0);
    cy  = (sum < a);
    f   = sf ? (sum == 0) : st[2];
    run_op(2'd0, a, b, sf, st, r, w, s, x);
    chk("R1", "add result", r, sum);
    chk("R1", "add write", {31'd0, w}, 1);
    chk("R2", "overflow", {31'd0, s[1]}, {31'd0, ov});
    chk("R3", "carry", {31'd0, s[0]}, {31'd0, cy});
    chk("R4", "flag and enable", {30'd0, s[3], s[2]}, {30'd0, st[3], f});
    chk("R5", "trap", {31'd0, x}, {31'd0, st[3] & ov});
  endtask

  task automatic t_div(input logic sgn, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [3:0] st);
    logic [W-1:0] r, q; logic w, x; logic [3:0] s;
    run_op(sgn ? 2'd1 : 2'd2, a, b, 1'b0, st, r, w, s, x);
    if (b == 0) begin
      chk("R6", "no write", {31'd0, w}, 0);
      chk("R6", "status", {28'd0, s}, {28'd0, st | 4'b0001});
      chk("R6", "trap", {31'd0, x}, 1);
    end else begin
      if (!sgn) q = a / b;
      else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) q = 32'h8000_0000;
      else q = $unsigned($signed(a) / $signed(b));
      chk(sgn ? "R7" : "R8", "quotient", r, q);
      chk(sgn ? "R7" : "R8", "write", {31'd0, w}, 1);
      chk(sgn ? "R7" : "R8", "status kept", {28'd0, s}, {28'd0, st});
      chk(sgn ? "R7" : "R8", "no trap", {31'd0, x}, 0);
    end
  endtask

  task automatic t_nop(input logic [3:0] st);
    logic [W-1:0] r; logic w, x; logic [3:0] s;
    run_op(2'd3, 32'h1234, 32'h5678, 1'b1, st, r, w, s, x);
    chk("R10", "no write", {31'd0, w}, 0);
    chk("R10", "status pass", {28'd0, s}, {28'd0, st});
    chk("R10", "no trap", {31'd0, x}, 0);
  endtask

  task automatic t_busy();
    int extra = 0; int guard = 0;
    @(negedge clk);
    op = 2'd2; opa = 32'd100; opb = 32'd7; status_in = 4'h5; in_valid = 1'b1;
    @(negedge clk);
    chk("R9", "ready low", {31'd0, in_ready}, 0);
    op = 2'd0; opa = 32'd1; opb = 32'd1; status_in = 4'h0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (out_valid) extra++;
    end
    in_valid = 1'b0;
    chk("R9", "no early completion", extra, 0);
    while (!out_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    chk("R9", "divide result", result, 32'd14);
    chk("R9", "divide status", {28'd0, status_out}, 32'h5);
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      if (out_valid) extra++;
      @(negedge clk);
    end
    chk("R9", "held request dropped", extra, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "in reset", {28'd0, out_valid, wr_en, range_exc, in_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "after reset", {28'd0, out_valid, wr_en, range_exc, in_ready}, 1);

    t_add(32'd5, 32'd7, 1'b1, 4'h0);
    t_add(32'h8000_0000, 32'h8000_0000, 1'b1, 4'h8);  // OV, CY, zero, trap
    t_add(32'hFFFF_FFFF, 32'd1, 1'b1, 4'h0);          // CY, zero, no OV
    t_add(32'hFFFF_FFFF, 32'd1, 1'b0, 4'h2);          // F untouched
    t_add(32'h7FFF_FFFF, 32'd1, 1'b0, 4'h8);          // positive overflow, trap
    t_add(32'h7FFF_FFFF, 32'd1, 1'b0, 4'h4);          // overflow, trap disabled
    t_add(32'hFFFF_FFF0, 32'd3, 1'b1, 4'hF);          // negative, clears flags

    t_div(1'b1, 32'd100, 32'd0, 4'h2);
    t_div(1'b0, 32'd9, 32'd0, 4'h9);
    t_div(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 4'hA);
    t_div(1'b1, -32'sd7, 32'd2, 4'h1);
    t_div(1'b1, 32'd7, -32'sd2, 4'h0);
    t_div(1'b1, -32'sd9, -32'sd3, 4'h8);
    t_div(1'b0, 32'hFFFF_FFFF, 32'd3, 4'h1);
    t_div(1'b0, 32'd5, 32'd9, 4'h0);

    t_nop(4'hB);
    t_busy();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule